// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a clocked host and an external static RAM that has no clock of its own. The host presents one request at a time through a request/ready handshake. Each request carries a word address, a write flag, a two-bit lane mask and write data. The controller turns the request into a pin sequence on the memory side. The memory pins are an address, an active-high chip select, an active-low chip enable, output enable, write enable, two active-low byte enables and a 16-bit data bus. The data bus is split into output, input and drive-enable, so a pad ring can build the tri-state buffer from them.

Every wait is a whole number of clocks. Each wait is derived at elaboration from a nanosecond figure and the clock period parameter, as ceil(ns / period) + 1. Writes are controlled by write enable. Output enable stays high for the whole write, and the controller leaves the bus undriven until the memory has had time to let go of it. Reads hold output enable low, sample the bus once the access count has run out, and hand the word to the host with a one-cycle valid pulse.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, and whenever no operation is active, `ready_o` is high. In that state the memory pins are idle: chip select low, chip enable, output enable and write enable high, both byte enables high, and the bus drive enable low.
- R2: A request is accepted on a rising clock edge where `req_i` and `ready_o` are both high. From the next cycle on, `ready_o` stays low for exactly WLEN cycles for a write and RLEN cycles for a read. Here Xc = ceil(X_ns / CLK_PERIOD_NS) + 1, PULSE = max(WPc, WZc + DSc), WLEN = max(WCc, PULSE + 1) and RLEN = max(RCc, AAc). With a 20 ns period and the default figures this gives 6 for a write and 4 for a read.
- R3: In a write, write enable goes low in the first active cycle and stays low for exactly PULSE consecutive cycles (5 at 20 ns).
- R4: In a write, the bus drive enable is low for the first WZc cycles of the write pulse. It is high from then through the first cycle after write enable has risen, and low afterwards. The data is therefore driven for at least DSc cycles before write enable rises.
- R5: Output enable is high throughout a write. The bus drive enable is never high while output enable is low.
- R6: During an active operation the address, chip select, chip enable and byte enables do not change. The address changes only while write enable is high.
- R7: Mask bit 0 selects the lower lane (data bits 7:0, byte enable bit 0). Mask bit 1 selects the upper lane (bits 15:8, byte enable bit 1). The byte enable of a selected lane is low for the whole operation, so a write updates only the selected lanes.
- R8: In a read, output enable is low and write enable is high for all RLEN active cycles. The bus is sampled at the end of active cycle AAc. `rvalid_o` is high for exactly one cycle, the cycle that follows that sample.
- R9: In a read, lanes not selected by the mask are returned as zero in `rdata_o`.
- R10: While `ready_o` is low, `req_i` and the request fields are ignored. They start no operation and change no pin or stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | Request strobe |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W (18) | Word address |
| mask_i | input | LANES (2) | Lane select, bit 0 lower byte |
| wdata_i | input | 16 | Write data |
| ready_o | output | 1 | Controller idle, request may be presented |
| rdata_o | output | 16 | Read data, unselected lanes zero |
| rvalid_o | output | 1 | One-cycle read data valid pulse |
| sram_addr_o | output | ADDR_W (18) | Memory address |
| sram_cs_o | output | 1 | Chip select, active high |
| sram_ce_n_o | output | 1 | Chip enable, active low |
| sram_oe_n_o | output | 1 | Output enable, active low |
| sram_we_n_o | output | 1 | Write enable, active low |
| sram_be_n_o | output | LANES (2) | Byte enables, active low, bit 0 lower |
| sram_dq_o | output | 16 | Data to the memory bus |
| sram_dq_i | input | 16 | Data from the memory bus |
| sram_dq_oe_o | output | 1 | Drive enable for the data bus |

## Verification
The bound checker watches, on every cycle, the exclusions and pulse shapes that hold whatever the traffic is. It checks that write enable and output enable are never low together and that the bus is never driven while output enable is low. It checks that the bus is released at each write-enable fall and that every write pulse has the exact length with enough driven setup before the rise. It also checks that the address holds while write enable is low, that the idle pins go with ready, and that read-valid lasts one cycle. Only the directed scenarios can show the values involved. Those are the occupancy counts seen by the host, that the stored word honours the lane mask, that unselected read lanes come back as zero, and that requests presented while busy leave the memory untouched.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2
    } op_state_e;

    // control pins of the memory, as one registered bundle
    typedef struct packed {
        logic cs;
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic dq_oe;
    } ctl_pins_t;

    localparam ctl_pins_t PINS_IDLE = '{cs: 1'b0, ce_n: 1'b1, oe_n: 1'b1,
                                        we_n: 1'b1, dq_oe: 1'b0};

    // wait count for a nanosecond figure: ceiling plus one cycle of margin
    function automatic int unsigned ns_to_cyc(input int unsigned ns,
                                              input int unsigned period);
        return (ns + period - 1) / period + 1;
    endfunction

    function automatic int unsigned max_u(input int unsigned a,
                                          input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // pin pattern for a given phase and active-cycle index
    function automatic ctl_pins_t pins_for(input op_state_e st,
                                           input int unsigned cnt,
                                           input int unsigned pulse,
                                           input int unsigned release_cyc);
        ctl_pins_t p;
        p = PINS_IDLE;
        case (st)
            ST_WRITE: begin
                p.cs    = 1'b1;
                p.ce_n  = 1'b0;
                p.oe_n  = 1'b1;
                p.we_n  = (cnt >= pulse);
                p.dq_oe = (cnt >= release_cyc) && (cnt <= pulse);
            end
            ST_READ: begin
                p.cs    = 1'b1;
                p.ce_n  = 1'b0;
                p.oe_n  = 1'b0;
                p.we_n  = 1'b1;
                p.dq_oe = 1'b0;
            end
            default: p = PINS_IDLE;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sram_op_seq.sv
module sram_op_seq
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned CNT_W   = 4,
    parameter int unsigned WR_LEN  = 6,
    parameter int unsigned RD_LEN  = 4,
    parameter int unsigned ACC_CYC = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             start_wr_i,
    output op_state_e        state_q,
    output op_state_e        state_d,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_d,
    output logic             capture_o
);

    localparam logic [CNT_W-1:0] WR_LAST  = CNT_W'(WR_LEN - 1);
    localparam logic [CNT_W-1:0] RD_LAST  = CNT_W'(RD_LEN - 1);
    localparam logic [CNT_W-1:0] ACC_LAST = CNT_W'(ACC_CYC - 1);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = start_wr_i ? ST_WRITE : ST_READ;
                    cnt_d   = '0;
                end
            end
            ST_WRITE: begin
                if (cnt_q == WR_LAST) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_READ: begin
                if (cnt_q == RD_LAST) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign capture_o = (state_q == ST_READ) && (cnt_q == ACC_LAST);

endmodule

// File: rtl/sram_pin_drv.sv
module sram_pin_drv
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W      = 18,
    parameter int unsigned LANES       = 2,
    parameter int unsigned LANE_W      = 8,
    parameter int unsigned CNT_W       = 4,
    parameter int unsigned PULSE_CYC   = 5,
    parameter int unsigned RELEASE_CYC = 2,
    localparam int unsigned DATA_W     = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept_i,
    input  op_state_e         state_d,
    input  logic [CNT_W-1:0]  cnt_d,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LANES-1:0]  mask_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [ADDR_W-1:0] addr_o,
    output ctl_pins_t         ctl_o,
    output logic [LANES-1:0]  be_n_o,
    output logic [DATA_W-1:0] dq_o
);

    ctl_pins_t ctl_d;

    // decode from the next phase so the registered pins line up with it
    always_comb begin
        ctl_d = pins_for(state_d, 32'(cnt_d), PULSE_CYC, RELEASE_CYC);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_o  <= PINS_IDLE;
            addr_o <= '0;
            dq_o   <= '0;
        end else begin
            ctl_o <= ctl_d;
            if (accept_i) begin
                addr_o <= addr_i;
                dq_o   <= wdata_i;
            end
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane_en
        always_ff @(posedge clk) begin
            if (rst) begin
                be_n_o[g] <= 1'b1;
            end else if (accept_i) begin
                be_n_o[g] <= ~mask_i[g];
            end else if (state_d == ST_IDLE) begin
                be_n_o[g] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
    parameter int unsigned LANES  = 2,
    parameter int unsigned LANE_W = 8,
    localparam int unsigned DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture_i,
    input  logic [LANES-1:0]  be_n_i,
    input  logic [DATA_W-1:0] dq_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rvalid_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid_o <= 1'b0;
        end else begin
            rvalid_o <= capture_i;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane_cap
        always_ff @(posedge clk) begin
            if (rst) begin
                rdata_o[g*LANE_W +: LANE_W] <= '0;
            end else if (capture_i) begin
                rdata_o[g*LANE_W +: LANE_W] <= be_n_i[g] ? '0
                                                         : dq_i[g*LANE_W +: LANE_W];
            end
        end
    end

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_NS = 10,
    parameter int unsigned T_WP_NS       = 45,
    parameter int unsigned T_WC_NS       = 55,
    parameter int unsigned T_DS_NS       = 25,
    parameter int unsigned T_WZ_NS       = 20,
    parameter int unsigned T_AA_NS       = 55,
    parameter int unsigned T_RC_NS       = 55,
    parameter int unsigned ADDR_W        = 18,
    parameter int unsigned LANES         = 2,
    parameter int unsigned LANE_W        = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       req_i,
    input  logic                       wr_i,
    input  logic [ADDR_W-1:0]          addr_i,
    input  logic [LANES-1:0]           mask_i,
    input  logic [LANES*LANE_W-1:0]    wdata_i,
    output logic                       ready_o,
    output logic [LANES*LANE_W-1:0]    rdata_o,
    output logic                       rvalid_o,
    output logic [ADDR_W-1:0]          sram_addr_o,
    output logic                       sram_cs_o,
    output logic                       sram_ce_n_o,
    output logic                       sram_oe_n_o,
    output logic                       sram_we_n_o,
    output logic [LANES-1:0]           sram_be_n_o,
    output logic [LANES*LANE_W-1:0]    sram_dq_o,
    input  logic [LANES*LANE_W-1:0]    sram_dq_i,
    output logic                       sram_dq_oe_o
);

    localparam int unsigned WP_C      = ns_to_cyc(T_WP_NS, CLK_PERIOD_NS);
    localparam int unsigned WC_C      = ns_to_cyc(T_WC_NS, CLK_PERIOD_NS);
    localparam int unsigned DS_C      = ns_to_cyc(T_DS_NS, CLK_PERIOD_NS);
    localparam int unsigned WZ_C      = ns_to_cyc(T_WZ_NS, CLK_PERIOD_NS);
    localparam int unsigned AA_C      = ns_to_cyc(T_AA_NS, CLK_PERIOD_NS);
    localparam int unsigned RC_C      = ns_to_cyc(T_RC_NS, CLK_PERIOD_NS);
    localparam int unsigned PULSE_CYC = max_u(WP_C, WZ_C + DS_C);
    localparam int unsigned WR_LEN    = max_u(WC_C, PULSE_CYC + 1);
    localparam int unsigned RD_LEN    = max_u(RC_C, AA_C);
    localparam int unsigned CNT_W     = $clog2(max_u(WR_LEN, RD_LEN) + 1);

    op_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             capture;
    logic             accept;
    ctl_pins_t        ctl;

    assign ready_o = (state_q == ST_IDLE);
    assign accept  = req_i && ready_o;

    sram_op_seq #(
        .CNT_W   (CNT_W),
        .WR_LEN  (WR_LEN),
        .RD_LEN  (RD_LEN),
        .ACC_CYC (AA_C)
    ) seq_i (
        .clk        (clk),
        .rst        (rst),
        .start_i    (accept),
        .start_wr_i (wr_i),
        .state_q    (state_q),
        .state_d    (state_d),
        .cnt_q      (cnt_q),
        .cnt_d      (cnt_d),
        .capture_o  (capture)
    );

    sram_pin_drv #(
        .ADDR_W      (ADDR_W),
        .LANES       (LANES),
        .LANE_W      (LANE_W),
        .CNT_W       (CNT_W),
        .PULSE_CYC   (PULSE_CYC),
        .RELEASE_CYC (WZ_C)
    ) pins_i (
        .clk      (clk),
        .rst      (rst),
        .accept_i (accept),
        .state_d  (state_d),
        .cnt_d    (cnt_d),
        .addr_i   (addr_i),
        .mask_i   (mask_i),
        .wdata_i  (wdata_i),
        .addr_o   (sram_addr_o),
        .ctl_o    (ctl),
        .be_n_o   (sram_be_n_o),
        .dq_o     (sram_dq_o)
    );

    sram_rd_capture #(
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) cap_i (
        .clk       (clk),
        .rst       (rst),
        .capture_i (capture),
        .be_n_i    (sram_be_n_o),
        .dq_i      (sram_dq_i),
        .rdata_o   (rdata_o),
        .rvalid_o  (rvalid_o)
    );

    assign sram_cs_o    = ctl.cs;
    assign sram_ce_n_o  = ctl.ce_n;
    assign sram_oe_n_o  = ctl.oe_n;
    assign sram_we_n_o  = ctl.we_n;
    assign sram_dq_oe_o = ctl.dq_oe;

endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
    parameter int unsigned ADDR_W    = 18,
    parameter int unsigned LANES     = 2,
    parameter int unsigned PULSE_CYC = 5,
    parameter int unsigned DS_CYC    = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              ready_o,
    input logic              rvalid_o,
    input logic [ADDR_W-1:0] sram_addr_o,
    input logic              sram_cs_o,
    input logic              sram_ce_n_o,
    input logic              sram_oe_n_o,
    input logic              sram_we_n_o,
    input logic [LANES-1:0]  sram_be_n_o,
    input logic              sram_dq_oe_o
);

    logic [7:0] we_low_cnt;
    logic [7:0] drv_low_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            we_low_cnt  <= '0;
            drv_low_cnt <= '0;
        end else if (!sram_we_n_o) begin
            we_low_cnt  <= we_low_cnt + 1'b1;
            drv_low_cnt <= drv_low_cnt + {7'd0, sram_dq_oe_o};
        end else begin
            we_low_cnt  <= '0;
            drv_low_cnt <= '0;
        end
    end

    // R1: idle handshake state goes with deselected pins
    a_r1_idle_pins: assert property (@(posedge clk) disable iff (rst)
        ready_o |-> (sram_ce_n_o && !sram_cs_o && sram_we_n_o && sram_oe_n_o
                     && !sram_dq_oe_o && (&sram_be_n_o)));

    // R2: host side is busy whenever the chip is enabled
    a_r2_busy_active: assert property (@(posedge clk) disable iff (rst)
        !sram_ce_n_o |-> !ready_o);

    // R3: write pulse length
    a_r3_pulse_len: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_we_n_o) |-> (we_low_cnt == 8'(PULSE_CYC)));

    // R4: bus undriven at the write-enable fall
    a_r4_release_at_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(sram_we_n_o) |-> !sram_dq_oe_o);

    // R4: data driven long enough before and through the rise
    a_r4_setup_hold: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_we_n_o) |-> (drv_low_cnt >= 8'(DS_CYC) && sram_dq_oe_o));

    // R5: output enable high during the write pulse
    a_r5_oe_in_write: assert property (@(posedge clk) disable iff (rst)
        !sram_we_n_o |-> sram_oe_n_o);

    // R5: no drive while memory outputs are enabled
    a_r5_no_contention: assert property (@(posedge clk) disable iff (rst)
        !sram_oe_n_o |-> !sram_dq_oe_o);

    // R6: address frozen while write enable is low
    a_r6_addr_hold: assert property (@(posedge clk) disable iff (rst)
        (!sram_we_n_o && $past(!sram_we_n_o)) |-> $stable(sram_addr_o));

    // R8: read valid is a single-cycle pulse
    a_r8_rvalid_pulse: assert property (@(posedge clk) disable iff (rst)
        rvalid_o |=> !rvalid_o);

endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(
    .ADDR_W    (ADDR_W),
    .LANES     (LANES),
    .PULSE_CYC (PULSE_CYC),
    .DS_CYC    (DS_C)
) chk_i (
    .clk          (clk),
    .rst          (rst),
    .ready_o      (ready_o),
    .rvalid_o     (rvalid_o),
    .sram_addr_o  (sram_addr_o),
    .sram_cs_o    (sram_cs_o),
    .sram_ce_n_o  (sram_ce_n_o),
    .sram_oe_n_o  (sram_oe_n_o),
    .sram_we_n_o  (sram_we_n_o),
    .sram_be_n_o  (sram_be_n_o),
    .sram_dq_oe_o (sram_dq_oe_o)
);

// File: tb/sram_lane_ctrl_tb_top.sv
module sram_lane_ctrl_tb_top;

    localparam int PER = 20;

    function automatic int cyc(input int ns);
        return (ns + PER - 1) / PER + 1;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int E_WZ    = cyc(20);
    localparam int E_DS    = cyc(25);
    localparam int E_AA    = cyc(55);
    localparam int E_PULSE = mx(cyc(45), E_WZ + E_DS);
    localparam int E_WLEN  = mx(cyc(55), E_PULSE + 1);
    localparam int E_RLEN  = mx(cyc(55), E_AA);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_i = 1'b0;
    logic        wr_i = 1'b0;
    logic [17:0] addr_i = '0;
    logic [1:0]  mask_i = '0;
    logic [15:0] wdata_i = '0;
    logic        ready_o, rvalid_o;
    logic [15:0] rdata_o;
    logic [17:0] sram_addr_o;
    logic        sram_cs_o, sram_ce_n_o, sram_oe_n_o, sram_we_n_o, sram_dq_oe_o;
    logic [1:0]  sram_be_n_o;
    logic [15:0] sram_dq_o, sram_dq_i;

    int n_chk = 0;
    int n_fail = 0;

    always #(PER/2) clk = ~clk;

    sram_lane_ctrl #(.CLK_PERIOD_NS(PER)) dut_i (
        .clk(clk), .rst(rst), .req_i(req_i), .wr_i(wr_i), .addr_i(addr_i),
        .mask_i(mask_i), .wdata_i(wdata_i), .ready_o(ready_o), .rdata_o(rdata_o),
        .rvalid_o(rvalid_o), .sram_addr_o(sram_addr_o), .sram_cs_o(sram_cs_o),
        .sram_ce_n_o(sram_ce_n_o), .sram_oe_n_o(sram_oe_n_o),
        .sram_we_n_o(sram_we_n_o), .sram_be_n_o(sram_be_n_o),
        .sram_dq_o(sram_dq_o), .sram_dq_i(sram_dq_i), .sram_dq_oe_o(sram_dq_oe_o)
    );

    // ---------------- memory model ----------------
    logic [15:0] mem [64];
    logic        mdl_drv;
    logic        we_prev = 1'b1;
    int          contention = 0;

    assign mdl_drv = sram_cs_o && !sram_ce_n_o && !sram_oe_n_o && sram_we_n_o
                     && !(&sram_be_n_o);
    assign sram_dq_i = mdl_drv ?
        { sram_be_n_o[1] ? 8'hA5 : mem[sram_addr_o[5:0]][15:8],
          sram_be_n_o[0] ? 8'hA5 : mem[sram_addr_o[5:0]][7:0] } : 16'hzzzz;

    always @(negedge clk) begin
        if (mdl_drv && sram_dq_oe_o) contention++;
        if (!we_prev && sram_we_n_o && sram_cs_o && !sram_ce_n_o) begin
            if (!sram_be_n_o[0]) mem[sram_addr_o[5:0]][7:0]  = sram_dq_o[7:0];
            if (!sram_be_n_o[1]) mem[sram_addr_o[5:0]][15:8] = sram_dq_o[15:8];
        end
        we_prev = sram_we_n_o;
    end

    // ---------------- check helper ----------------
    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    // per-operation observations
    int busy, we_lo, drv_lo_pre, early_drv, oe_lo_wr, pin_chg, addr_chg_we_lo;
    int rv_cnt, rv_idx, n_we_fall;
    logic [15:0] rv_data;

    // one operation; optionally pokes the request lines while busy
    task automatic run_op(input bit wr, input logic [17:0] a, input logic [1:0] m,
                          input logic [15:0] d, input bit poke);
        logic [17:0] pa;
        logic [1:0]  pb;
        logic        pce, pwe;
        int idx;
        while (!ready_o) @(negedge clk);
        req_i = 1'b1; wr_i = wr; addr_i = a; mask_i = m; wdata_i = d;
        @(negedge clk);
        req_i = 1'b0;
        busy = 0; we_lo = 0; drv_lo_pre = 0; early_drv = 0; oe_lo_wr = 0;
        pin_chg = 0; addr_chg_we_lo = 0; rv_cnt = 0; rv_idx = -1; n_we_fall = 0;
        rv_data = '0;
        idx = 0;
        pa = sram_addr_o; pb = sram_be_n_o; pce = sram_ce_n_o; pwe = 1'b1;
        while (!ready_o && idx < 100) begin
            busy++;
            if (!sram_we_n_o) begin
                if (pwe) n_we_fall++;
                if (sram_dq_oe_o) drv_lo_pre++;
                else if (we_lo >= E_WZ) early_drv++;
                if (sram_dq_oe_o && we_lo < E_WZ) early_drv++;
                we_lo++;
                if (!sram_oe_n_o) oe_lo_wr++;
                if (sram_addr_o != pa) addr_chg_we_lo++;
            end
            if (sram_addr_o != pa || sram_be_n_o != pb || sram_ce_n_o != pce) pin_chg++;
            if (rvalid_o) begin rv_cnt++; rv_idx = idx; rv_data = rdata_o; end
            pa = sram_addr_o; pwe = sram_we_n_o;
            if (poke) begin
                req_i = 1'b1; wr_i = 1'b1; addr_i = a + 18'd1; mask_i = 2'b11;
                wdata_i = 16'hBEEF;
            end
            idx++;
            @(negedge clk);
            if (ready_o) req_i = 1'b0;
        end
        req_i = 1'b0;
        if (rvalid_o) begin rv_cnt++; rv_idx = idx; rv_data = rdata_o; end
        @(negedge clk);
        if (rvalid_o) rv_cnt++;
    endtask

    task automatic t_reset;
        chk(ready_o && sram_ce_n_o && !sram_cs_o && sram_we_n_o && sram_oe_n_o
            && !sram_dq_oe_o && sram_be_n_o == 2'b11 && !rvalid_o,
            "R1 reset idle pins", {sram_cs_o, sram_ce_n_o, sram_oe_n_o, sram_we_n_o},
            4'b0111);
    endtask

    task automatic t_word_write;
        run_op(1'b1, 18'd5, 2'b11, 16'h1234, 1'b0);
        chk(busy == E_WLEN, "R2 write busy cycles", busy, E_WLEN);
        chk(we_lo == E_PULSE, "R3 write pulse cycles", we_lo, E_PULSE);
        chk(drv_lo_pre == E_PULSE - E_WZ && early_drv == 0,
            "R4 drive window before rise", drv_lo_pre, E_PULSE - E_WZ);
        chk(oe_lo_wr == 0, "R5 oe high in write", oe_lo_wr, 0);
        chk(pin_chg == 0, "R6 pins stable during write", pin_chg, 0);
        chk(mem[5] == 16'h1234, "R7 word stored", mem[5], 16'h1234);
        chk(ready_o && sram_ce_n_o, "R1 idle after write", sram_ce_n_o, 1);
    endtask

    task automatic t_word_read;
        run_op(1'b0, 18'd5, 2'b11, 16'h0, 1'b0);
        chk(busy == E_RLEN, "R2 read busy cycles", busy, E_RLEN);
        chk(rv_cnt == 1, "R8 rvalid single pulse", rv_cnt, 1);
        chk(rv_idx == E_AA, "R8 rvalid timing", rv_idx, E_AA);
        chk(rv_data == 16'h1234, "R8 read data", rv_data, 16'h1234);
    endtask

    task automatic t_lane_write;
        run_op(1'b1, 18'd5, 2'b10, 16'hABCD, 1'b0);
        chk(mem[5] == 16'hAB34, "R7 upper lane only", mem[5], 16'hAB34);
        run_op(1'b1, 18'd5, 2'b01, 16'h77EE, 1'b0);
        chk(mem[5] == 16'hABEE, "R7 lower lane only", mem[5], 16'hABEE);
    endtask

    task automatic t_lane_read;
        run_op(1'b0, 18'd5, 2'b01, 16'h0, 1'b0);
        chk(rv_data == 16'h00EE, "R9 lower lane read, upper zero", rv_data, 16'h00EE);
        run_op(1'b0, 18'd5, 2'b10, 16'h0, 1'b0);
        chk(rv_data == 16'hAB00, "R9 upper lane read, lower zero", rv_data, 16'hAB00);
    endtask

    task automatic t_back_to_back;
        run_op(1'b1, 18'd7, 2'b11, 16'h5A5A, 1'b0);
        run_op(1'b1, 18'd8, 2'b11, 16'hC3C3, 1'b0);
        chk(addr_chg_we_lo == 0 && pin_chg == 0, "R6 address change only with we high",
            addr_chg_we_lo, 0);
        chk(mem[7] == 16'h5A5A && mem[8] == 16'hC3C3, "R7 consecutive writes",
            mem[8], 16'hC3C3);
    endtask

    task automatic t_busy_ignore;
        run_op(1'b1, 18'd20, 2'b11, 16'h1111, 1'b1);
        chk(busy == E_WLEN && n_we_fall == 1, "R10 busy requests ignored", busy, E_WLEN);
        chk(mem[21] == 16'h0000, "R10 poked address untouched", mem[21], 0);
        chk(ready_o && sram_ce_n_o, "R10 no operation started after poke",
            sram_ce_n_o, 1);
        chk(contention == 0, "R5 no bus contention", contention, 0);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 16'h0000;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_word_write();
        t_word_read();
        t_lane_write();
        t_lane_read();
        t_back_to_back();
        t_busy_ignore();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(PER * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule